// File: doc/BRIEF.md
# PHY Initialization Pulse Sequencer

When the card clock of a high-speed memory-card PHY changes frequency, or is stopped and restarted, or when its timing or function settings are rewritten, the PHY has to be resynchronized. This block produces that resynchronization. Software owns one 32-bit control word. The low 16 bits hold four 4-bit phase lengths, counted in bus clocks. Two mode bits are ordinary read/write storage. Writing a 1 to the top bit starts a run. The top bit then reads back as 1 until the whole run has finished and clears by itself, so software can poll it.

A run goes through four phases in a fixed order. First the sync-enable strobe is held high. Then comes a quiet gap. Then the sync-reset strobe is held high. Then comes a settle wait. A fixed tail of 8 cycles always follows the settle wait. It stands for four bus-clock and four interconnect-clock cycles, with both clock domains modelled as one clock. A phase whose field is zero takes no cycles. A busy output covers the whole run, and a one-cycle done pulse marks its end. While a run is in progress the control word is frozen and every write is dropped.

Top module: `phy_sync_sequencer`

## Requirements
- R1: Bit 31 of the control word reads 1 from the edge that accepts a start write until the edge that ends the run, where it returns to 0 without any further write.
- R2: A write with bit 31 set while idle raises `busy_o` on that same clock edge. `busy_o` then stays high for exactly EN+GAP+RST+SET+8 cycles, where EN, GAP, RST and SET are the field values of that write.
- R3: `sync_en_o` is high for exactly EN cycles, where EN is bits [11:8]. These cycles start right after the accepting edge, and `sync_en_o` is high at no other time.
- R4: After sync-enable come GAP cycles (bits [7:4]) with both strobes low. Then `sync_rst_o` is high for exactly RST cycles (bits [3:0]), and it is high at no other time.
- R5: After sync-reset come SET cycles (bits [15:12]) and then a fixed 8-cycle tail. During both, the two strobes are low and `busy_o` stays high.
- R6: A field value of zero removes its phase completely, so the following phase moves forward. With all four fields zero, the run lasts only the 8-cycle tail.
- R7: Bit 29 (slow mode, `slow_mode_o`) and bit 28 (SDIO mode, `sdio_mode_o`) are read/write. They are taken from the same write that starts a run and keep their value through the run and after it.
- R8: Any write accepted while `busy_o` is high is ignored as a whole. This covers the start bit, the phase fields and the mode bits, and the run in progress keeps its original timing.
- R9: `done_o` is high for exactly one cycle: the first cycle in which `busy_o` is low after a run.
- R10: After reset the control word reads 0 and all outputs are low. Bits 30 and 27:16 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data for the control word |
| rd_data_o | output | 32 | Current control word value |
| sync_en_o | output | 1 | Sync-enable strobe to the PHY |
| sync_rst_o | output | 1 | Sync-reset strobe to the PHY |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse when a run completes |
| slow_mode_o | output | 1 | Slow (bypass) mode setting |
| sdio_mode_o | output | 1 | SDIO mode setting |

## Verification
The bench traces every strobe cycle by cycle against windows it works out from the field values. A design that counts a phase one cycle short or long, or that swaps the enable and reset fields, puts an edge in the wrong sample. Runs with zero fields check that an empty phase is skipped rather than held for a full 16 cycles, which would happen if the counter wrapped. Runs with all fields at 15 check the counter at its widest value. A write dropped into the middle of a run checks that the start bit is not re-armed, that the fields are not changed and that the run is not lengthened. Another check confirms that the start bit self-clears on the same edge that busy falls and that done lasts only one cycle.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;

    // Control word bit positions that software decodes
    localparam int START_BIT = 31;
    localparam int SLOW_BIT  = 29;
    localparam int SDIO_BIT  = 28;

    // Phase order is encoded in the enum value (lower runs first)
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_EN     = 3'd1,
        PH_GAP    = 3'd2,
        PH_RST    = 3'd3,
        PH_SETTLE = 3'd4,
        PH_TAIL   = 3'd5
    } phase_e;

endpackage

// File: rtl/phy_init_regs.sv
module phy_init_regs
    import phy_init_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              busy_i,
    input  logic              finish_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [4*FLD_W-1:0] dur_o,
    output logic              launch_o,
    output logic              slow_o,
    output logic              sdio_o
);

    localparam int DUR_W = 4 * FLD_W;

    typedef struct packed {
        logic             start;
        logic             slow;
        logic             sdio;
        logic [DUR_W-1:0] dur;
    } regs_s;

    regs_s r_d, r_q;
    logic  accept;

    // Reserved write bits are intentionally discarded
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data_i[DATA_W-1:DUR_W]};

    always_comb begin
        r_d    = r_q;
        accept = wr_en_i && !busy_i;
        if (accept) begin
            r_d.start = wr_data_i[START_BIT];
            r_d.slow  = wr_data_i[SLOW_BIT];
            r_d.sdio  = wr_data_i[SDIO_BIT];
            r_d.dur   = wr_data_i[DUR_W-1:0];
        end
        if (finish_i) begin
            r_d.start = 1'b0;
        end
        launch_o = accept && wr_data_i[START_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data_o            = '0;
        rd_data_o[START_BIT] = r_q.start;
        rd_data_o[SLOW_BIT]  = r_q.slow;
        rd_data_o[SDIO_BIT]  = r_q.sdio;
        rd_data_o[DUR_W-1:0] = r_q.dur;
    end

    assign dur_o  = r_q.dur;
    assign slow_o = r_q.slow;
    assign sdio_o = r_q.sdio;

    AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && wr_en_i) |=> ($stable(r_q.dur) && $stable(r_q.slow) && $stable(r_q.sdio))) // R8
        else $error("write accepted while busy");

endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
    import phy_init_pkg::*;
#(
    parameter int FLD_W    = 4,
    parameter int TAIL_LEN = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch_i,
    input  logic [4*FLD_W-1:0] launch_dur_i,
    input  logic [4*FLD_W-1:0] run_dur_i,
    output logic               sync_en_o,
    output logic               sync_rst_o,
    output logic               busy_o,
    output logic               finish_o,
    output logic               done_o
);

    localparam int DUR_W   = 4 * FLD_W;
    localparam int FLD_MAX = (1 << FLD_W);
    localparam int MAX_LEN = (FLD_MAX > TAIL_LEN) ? FLD_MAX : TAIL_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } seq_s;

    typedef struct packed {
        phase_e         ph;
        logic [CNT_W:0] len;
    } pick_s;

    seq_s s_d, s_q;

    function automatic logic [CNT_W:0] phase_len(phase_e p, logic [DUR_W-1:0] d);
        logic [CNT_W:0] l;
        l = '0;
        case (p)
            PH_RST:    l = (CNT_W+1)'(d[0*FLD_W +: FLD_W]);
            PH_GAP:    l = (CNT_W+1)'(d[1*FLD_W +: FLD_W]);
            PH_EN:     l = (CNT_W+1)'(d[2*FLD_W +: FLD_W]);
            PH_SETTLE: l = (CNT_W+1)'(d[3*FLD_W +: FLD_W]);
            PH_TAIL:   l = (CNT_W+1)'(TAIL_LEN);
            default:   l = '0;
        endcase
        return l;
    endfunction

    // First phase at or after from_ph whose length is non-zero
    function automatic pick_s next_active(phase_e from_ph, logic [DUR_W-1:0] d);
        pick_s p;
        p.ph  = PH_TAIL;
        p.len = (CNT_W+1)'(TAIL_LEN);
        for (int k = 5; k >= 1; k--) begin
            phase_e cand;
            cand = phase_e'(k[2:0]);
            if (k[2:0] >= from_ph && phase_len(cand, d) != '0) begin
                p.ph  = cand;
                p.len = phase_len(cand, d);
            end
        end
        return p;
    endfunction

    always_comb begin
        pick_s pk;
        s_d      = s_q;
        s_d.done = 1'b0;
        finish_o = 1'b0;
        pk       = '{ph: PH_TAIL, len: '0};
        if (s_q.ph == PH_IDLE) begin
            if (launch_i) begin
                pk      = next_active(PH_EN, launch_dur_i);
                s_d.ph  = pk.ph;
                s_d.cnt = CNT_W'(pk.len - 1'b1);
            end
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else if (s_q.ph == PH_TAIL) begin
            s_d.ph   = PH_IDLE;
            s_d.done = 1'b1;
            finish_o = 1'b1;
        end else begin
            pk      = next_active(phase_e'(3'(s_q.ph) + 3'd1), run_dur_i);
            s_d.ph  = pk.ph;
            s_d.cnt = CNT_W'(pk.len - 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_en_o  = (s_q.ph == PH_EN);
    assign sync_rst_o = (s_q.ph == PH_RST);
    assign busy_o     = (s_q.ph != PH_IDLE);
    assign done_o     = s_q.done;

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))) // R9
        else $error("done without a preceding run");

    AST_TAIL_BEFORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(s_q.ph) == PH_TAIL)) // R5
        else $error("run ended without the tail");

endmodule

// File: rtl/phy_sync_sequencer.sv
module phy_sync_sequencer
    import phy_init_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int FLD_W    = 4,
    parameter int TAIL_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              sync_en_o,
    output logic              sync_rst_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              slow_mode_o,
    output logic              sdio_mode_o
);

    localparam int DUR_W = 4 * FLD_W;

    logic [DUR_W-1:0] run_dur;
    logic             launch;
    logic             finish;

    phy_init_regs #(.DATA_W(DATA_W), .FLD_W(FLD_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .busy_i    (busy_o),
        .finish_i  (finish),
        .rd_data_o (rd_data_o),
        .dur_o     (run_dur),
        .launch_o  (launch),
        .slow_o    (slow_mode_o),
        .sdio_o    (sdio_mode_o)
    );

    phy_init_seq #(.FLD_W(FLD_W), .TAIL_LEN(TAIL_LEN)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_i     (launch),
        .launch_dur_i (wr_data_i[DUR_W-1:0]),
        .run_dur_i    (run_dur),
        .sync_en_o    (sync_en_o),
        .sync_rst_o   (sync_rst_o),
        .busy_o       (busy_o),
        .finish_o     (finish),
        .done_o       (done_o)
    );

    AST_START_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[START_BIT] == busy_o) // R1
        else $error("start bit and busy disagree");

    AST_LAUNCH_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[START_BIT] && !busy_o) |=> busy_o) // R2
        else $error("start write did not launch");

endmodule

// File: tb/phy_sync_sequencer_bench.sv
`timescale 1ns/1ps
module phy_sync_sequencer_bench;

    localparam real CLK_NS = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        sync_en, sync_rst, busy, done, slow_mode, sdio_mode;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    phy_sync_sequencer u_phy_sync_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .rd_data_o   (rd_data),
        .sync_en_o   (sync_en),
        .sync_rst_o  (sync_rst),
        .busy_o      (busy),
        .done_o      (done),
        .slow_mode_o (slow_mode),
        .sdio_mode_o (sdio_mode)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Ends at the falling edge right after the accepting rising edge
    task automatic write_word(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic check_reset();
        chk(rd_data == 32'h0, "R10", "reset word", rd_data, 0);
        chk({sync_en, sync_rst, busy, done, slow_mode, sdio_mode} == 6'b0,
            "R10", "reset outputs",
            {sync_en, sync_rst, busy, done, slow_mode, sdio_mode}, 0);
    endtask

    // Start a run and trace it; optionally inject a write at sample 3
    task automatic run_seq(input int e, input int g, input int r, input int s,
                           input logic [1:0] modes, input bit inject);
        int total;
        logic [31:0] word;
        logic en_t[0:79], rst_t[0:79], busy_t[0:79], done_t[0:79], st_t[0:79];
        int bad_en, bad_rst, bad_busy, bad_done, bad_st;
        int f_en, f_rst, f_busy, f_done, f_st;
        total = e + g + r + s + 8;
        word = {1'b1, 1'b0, modes, 12'h0, s[3:0], e[3:0], g[3:0], r[3:0]};
        write_word(word);
        for (int i = 0; i < total + 3; i++) begin
            en_t[i]   = sync_en;
            rst_t[i]  = sync_rst;
            busy_t[i] = busy;
            done_t[i] = done;
            st_t[i]   = rd_data[31];
            if (inject && i == 3) begin
                wr_en   = 1'b1;
                wr_data = 32'hB000_1111;
            end else begin
                wr_en   = 1'b0;
                wr_data = '0;
            end
            @(negedge clk);
        end
        bad_en = 0; bad_rst = 0; bad_busy = 0; bad_done = 0; bad_st = 0;
        f_en = -1; f_rst = -1; f_busy = -1; f_done = -1; f_st = -1;
        for (int i = 0; i < total + 3; i++) begin
            logic x_en, x_rst, x_busy, x_done;
            x_en   = (i < e);
            x_rst  = (i >= e + g) && (i < e + g + r);
            x_busy = (i < total);
            x_done = (i == total);
            if (en_t[i] !== x_en)     begin bad_en++;   if (f_en < 0)   f_en = i;   end
            if (rst_t[i] !== x_rst)   begin bad_rst++;  if (f_rst < 0)  f_rst = i;  end
            if (busy_t[i] !== x_busy) begin bad_busy++; if (f_busy < 0) f_busy = i; end
            if (done_t[i] !== x_done) begin bad_done++; if (f_done < 0) f_done = i; end
            if (st_t[i] !== x_busy)   begin bad_st++;   if (f_st < 0)   f_st = i;   end
        end
        chk(bad_en == 0, "R3", $sformatf("sync_en window e=%0d first bad sample", e), f_en, -1);
        chk(bad_rst == 0, "R4", $sformatf("sync_rst window g=%0d r=%0d first bad sample", g, r), f_rst, -1);
        chk(bad_busy == 0, "R2", $sformatf("busy length %0d first bad sample", total), f_busy, -1);
        chk(bad_done == 0, "R9", "done pulse first bad sample", f_done, -1);
        chk(bad_st == 0, "R1", "start bit self-clear first bad sample", f_st, -1);
        chk(rd_data == {4'b0, modes, 12'h0, s[3:0], e[3:0], g[3:0], r[3:0]},
            "R7", "word after run", rd_data, {4'b0, modes, 12'h0, s[3:0], e[3:0], g[3:0], r[3:0]});
        chk({slow_mode, sdio_mode} == modes, "R7", "mode outputs after run",
            {slow_mode, sdio_mode}, modes);
    endtask

    task automatic test_modes();
        write_word(32'h3000_0000);
        chk(rd_data == 32'h3000_0000, "R7", "both modes set", rd_data, 32'h3000_0000);
        chk(slow_mode && sdio_mode, "R7", "mode pins", {slow_mode, sdio_mode}, 2'b11);
        chk(!busy, "R7", "mode write starts nothing", busy, 0);
        write_word(32'h4FFF_0000);
        chk(rd_data == 32'h0, "R10", "reserved bits read zero", rd_data, 0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset();
        run_seq(1, 1, 1, 1, 2'b00, 1'b0);
        run_seq(3, 2, 5, 4, 2'b10, 1'b0);
        run_seq(15, 15, 15, 15, 2'b01, 1'b0);
        // R6: all phases empty, then empty enable and reset phases
        run_seq(0, 0, 0, 0, 2'b00, 1'b0);
        run_seq(0, 3, 0, 2, 2'b00, 1'b0);
        run_seq(2, 0, 3, 0, 2'b11, 1'b0);
        // R8: write during the run must be dropped
        run_seq(2, 2, 2, 2, 2'b00, 1'b1);
        chk(!busy && !done, "R8", "no relaunch after dropped write", {busy, done}, 0);
        test_modes();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule